// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. Every entry remembers a virtual page number, the physical frame it maps to, a global flag and the 12-bit address-space tag that was current when the entry was filled. A page walker or a miss handler installs entries through the fill port. The load/store path presents virtual page numbers on the lookup port and gets hit, frame and global flag back one cycle later.

The block also holds the page-table root register. Software writes it when it switches address spaces. A side input turns tagging on. When tagging is on, the low 12 bits of the root value name the current address space. When tagging is off, those bits are cache-control flags and the current tag is zero. Each root write applies a selective flush, chosen from the tagging mode and a keep bit that travels with the write. A separate strobe wipes the whole cache, global entries included.

Top module: `tagtlb`

## Requirements
- R1: After reset every entry is invalid, `root_o` is zero, `lk_vld_o` is low, and every lookup misses.
- R2: A lookup request presented in cycle n produces `lk_vld_o` high in cycle n+1 only, with `lk_hit_o`, `lk_pfn_o` and `lk_glb_o` valid there. A miss returns frame 0 and global flag 0.
- R3: A lookup hits only on a valid entry whose page number equals the request and that is global or carries a tag equal to the effective tag. The effective tag is `root_o[11:0]` when `tag_en_i` is 1 and zero when it is 0. A fill stores the effective tag of its cycle.
- R4: A root write with `tag_en_i` = 0 invalidates every non-global entry and keeps every global entry.
- R5: A root write with `tag_en_i` = 1 and `root_keep_i` = 1 invalidates nothing. Entries filled earlier under a tag hit again once that tag is loaded again.
- R6: A root write with `tag_en_i` = 1 and `root_keep_i` = 0 invalidates exactly the non-global entries whose tag equals bits 11:0 of the written value. Entries of other tags survive.
- R7: A global entry hits under any tag and with tagging on or off.
- R8: A root write takes effect from the next cycle. A lookup issued in the same cycle as the write sees the old tag and the old contents.
- R9: A fill whose page would already hit overwrites that entry in place, so no duplicate is made and the new frame is returned.
- R10: A fill with no matching entry takes the lowest-numbered invalid entry. When all 16 entries are valid, it replaces entries in round-robin order starting from entry 0.
- R11: `flush_all_i` invalidates every entry, global ones included, from the next cycle. A fill in the same cycle is dropped.
- R12: `root_o` holds the most recently written root value, from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_en_i | input | 1 | Address-space tagging enable |
| root_wr_i | input | 1 | Root register write strobe |
| root_val_i | input | 32 | Root value; bits 11:0 are the tag when tagging is on |
| root_keep_i | input | 1 | Keep cached entries on this root write (tagging on only) |
| flush_all_i | input | 1 | Invalidate every entry, global ones included |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_pfn_i | input | 20 | Physical frame number to install |
| fill_glb_i | input | 1 | Global flag of the installed translation |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Virtual page number to look up |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 20 | Frame number on a hit, zero on a miss |
| lk_glb_o | output | 1 | Global flag of the hit entry |
| root_o | output | 32 | Current root register value |

## Verification
The bench switches between two tags with and without the keep bit. A design that flushed every tag on a non-keeping write would lose the other tag's entry. One that ignored the keep bit would lose a revisited address space. One that never cleared would return a stale frame for the reloaded tag. The bench turns tagging off without a root write, which catches a design that latches the tag instead of forcing it to zero, and it looks up in the very cycle of a root write to catch a flush that applies too early. It refills a page to expose duplicate entries, then fills past capacity to check which entry is evicted, and it checks that the full wipe removes global entries and drops a fill in the same cycle.

// File: rtl/tagtlb_pkg.sv
package tagtlb_pkg;

  localparam int unsigned TLB_ENTRIES = 16;
  localparam int unsigned TLB_VPN_W   = 20;
  localparam int unsigned TLB_PFN_W   = 20;
  localparam int unsigned TLB_TAG_W   = 12;
  localparam int unsigned TLB_ROOT_W  = 32;

  // Invalidation applied to the array on a root register write
  typedef enum logic [1:0] {
    FL_NONE      = 2'd0,
    FL_NONGLOBAL = 2'd1,
    FL_TAG       = 2'd2
  } flush_kind_e;

endpackage

// File: rtl/tagtlb_rst_sync.sv
module tagtlb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tagtlb_match.sv
module tagtlb_match #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned TAG_W   = 12,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0]            glb_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              key_vpn_i,
  input  logic [TAG_W-1:0]              key_tag_i,
  output logic [ENTRIES-1:0]            hits_o,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic page_eq;
    logic space_ok;
    assign page_eq  = (vpn_i[g] == key_vpn_i);
    assign space_ok = glb_i[g] | (tag_i[g] == key_tag_i);
    assign hits_o[g] = valid_i[g] & page_eq & space_ok;
  end

  assign any_o = |hits_o;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hits_o[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tagtlb_victim.sv
module tagtlb_victim #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               adv_i,
  output logic               free_any_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic [IDX_W-1:0]   rr_idx_o
);

  logic [IDX_W-1:0] rr_q, rr_d;

  assign free_any_o = ~&valid_i;

  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (adv_i) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_d = '0;
      else                             rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (adv_i) rr_q <= rr_d;
  end

  assign rr_idx_o = rr_q;

  // R10
  rr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> rr_q != $past(rr_q));

endmodule

// File: rtl/tagtlb.sv
module tagtlb
  import tagtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  parameter int unsigned VPN_W   = TLB_VPN_W,
  parameter int unsigned PFN_W   = TLB_PFN_W,
  parameter int unsigned TAG_W   = TLB_TAG_W,
  parameter int unsigned ROOT_W  = TLB_ROOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_en_i,
  input  logic              root_wr_i,
  input  logic [ROOT_W-1:0] root_val_i,
  input  logic              root_keep_i,
  input  logic              flush_all_i,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_glb_i,
  input  logic              lk_req_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              lk_glb_o,
  output logic [ROOT_W-1:0] root_o
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic rst_s_n;

  tagtlb_rst_sync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_s_n)
  );

  // Entry array state
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0]            glb_q,   glb_d;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,   vpn_d;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q,   pfn_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q,   tag_d;
  logic [ROOT_W-1:0]             root_q;

  logic [TAG_W-1:0] eff_tag;
  logic [TAG_W-1:0] new_tag;
  flush_kind_e      flush_kind;
  logic             arr_en;

  assign eff_tag = tag_en_i ? root_q[TAG_W-1:0]     : '0;
  assign new_tag = tag_en_i ? root_val_i[TAG_W-1:0] : '0;

  always_comb begin
    if (!root_wr_i)       flush_kind = FL_NONE;
    else if (!tag_en_i)   flush_kind = FL_NONGLOBAL;
    else if (root_keep_i) flush_kind = FL_NONE;
    else                  flush_kind = FL_TAG;
  end

  // Lookup and fill comparators
  logic [ENTRIES-1:0] lk_hits, fl_hits;
  logic               lk_any,  fl_any;
  logic [IDX_W-1:0]   lk_idx,  fl_idx;

  tagtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_lk_match (
    .valid_i   (valid_q),
    .glb_i     (glb_q),
    .vpn_i     (vpn_q),
    .tag_i     (tag_q),
    .key_vpn_i (lk_vpn_i),
    .key_tag_i (eff_tag),
    .hits_o    (lk_hits),
    .any_o     (lk_any),
    .idx_o     (lk_idx)
  );

  tagtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TAG_W(TAG_W)) u_fl_match (
    .valid_i   (valid_q),
    .glb_i     (glb_q),
    .vpn_i     (vpn_q),
    .tag_i     (tag_q),
    .key_vpn_i (fill_vpn_i),
    .key_tag_i (eff_tag),
    .hits_o    (fl_hits),
    .any_o     (fl_any),
    .idx_o     (fl_idx)
  );

  // Replacement choice
  logic             free_any;
  logic [IDX_W-1:0] free_idx, rr_idx;
  logic             rr_adv;
  logic [IDX_W-1:0] fill_idx;

  assign rr_adv = fill_i & ~flush_all_i & ~fl_any & ~free_any;

  tagtlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .valid_i    (valid_q),
    .adv_i      (rr_adv),
    .free_any_o (free_any),
    .free_idx_o (free_idx),
    .rr_idx_o   (rr_idx)
  );

  always_comb begin
    if (fl_any)        fill_idx = fl_idx;
    else if (free_any) fill_idx = free_idx;
    else               fill_idx = rr_idx;
  end

  // Array next state
  always_comb begin
    valid_d = valid_q;
    glb_d   = glb_q;
    vpn_d   = vpn_q;
    pfn_d   = pfn_q;
    tag_d   = tag_q;
    if (flush_all_i) begin
      valid_d = '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        unique case (flush_kind)
          FL_NONGLOBAL: if (!glb_q[i]) valid_d[i] = 1'b0;
          FL_TAG:       if (!glb_q[i] && tag_q[i] == new_tag) valid_d[i] = 1'b0;
          default:      ;
        endcase
      end
      if (fill_i) begin
        valid_d[fill_idx] = 1'b1;
        glb_d[fill_idx]   = fill_glb_i;
        vpn_d[fill_idx]   = fill_vpn_i;
        pfn_d[fill_idx]   = fill_pfn_i;
        tag_d[fill_idx]   = eff_tag;
      end
    end
  end

  assign arr_en = flush_all_i | fill_i | root_wr_i;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    valid_q <= '0;
    else if (arr_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_i) begin
      glb_q <= glb_d;
      vpn_q <= vpn_d;
      pfn_q <= pfn_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)       root_q <= '0;
    else if (root_wr_i) root_q <= root_val_i;
  end

  assign root_o = root_q;

  // Lookup response stage
  logic             lk_vld_q, lk_hit_q, lk_glb_q;
  logic             lk_hit_d, lk_glb_d;
  logic [PFN_W-1:0] lk_pfn_q, lk_pfn_d;

  always_comb begin
    lk_hit_d = lk_any;
    lk_pfn_d = lk_any ? pfn_q[lk_idx] : '0;
    lk_glb_d = lk_any & glb_q[lk_idx];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) lk_vld_q <= 1'b0;
    else          lk_vld_q <= lk_req_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      lk_hit_q <= 1'b0;
      lk_pfn_q <= '0;
      lk_glb_q <= 1'b0;
    end else if (lk_req_i) begin
      lk_hit_q <= lk_hit_d;
      lk_pfn_q <= lk_pfn_d;
      lk_glb_q <= lk_glb_d;
    end
  end

  assign lk_vld_o = lk_vld_q;
  assign lk_hit_o = lk_hit_q;
  assign lk_pfn_o = lk_pfn_q;
  assign lk_glb_o = lk_glb_q;

  // R2
  lk_resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    lk_req_i |=> lk_vld_o);
  // R2
  lk_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !lk_req_i |=> !lk_vld_o);
  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(lk_hits));
  // R11
  wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush_all_i |=> valid_q == '0);
  // R4
  untagged_switch_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (root_wr_i && !tag_en_i && !fill_i && !flush_all_i) |=> (valid_q & ~glb_q) == '0);
  // R5
  keep_switch_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (root_wr_i && tag_en_i && root_keep_i && !fill_i && !flush_all_i)
      |=> valid_q == $past(valid_q));
  // R10
  stays_full_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fill_i && !flush_all_i && !root_wr_i && (&valid_q)) |=> (&valid_q));
  // R12
  root_load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    root_wr_i |=> root_o == $past(root_val_i));

endmodule

// File: tb/tagtlb_bench.sv
`timescale 1ns/1ps
module tagtlb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tag_en_i, root_wr_i, root_keep_i, flush_all_i;
  logic [31:0] root_val_i;
  logic        fill_i, fill_glb_i, lk_req_i;
  logic [19:0] fill_vpn_i, fill_pfn_i, lk_vpn_i;
  logic        lk_vld_o, lk_hit_o, lk_glb_o;
  logic [19:0] lk_pfn_o;
  logic [31:0] root_o;

  always #2 clk = ~clk;

  tagtlb u_tagtlb (
    .clk(clk), .rst_n(rst_n), .tag_en_i(tag_en_i), .root_wr_i(root_wr_i),
    .root_val_i(root_val_i), .root_keep_i(root_keep_i), .flush_all_i(flush_all_i),
    .fill_i(fill_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_glb_i(fill_glb_i), .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i),
    .lk_vld_o(lk_vld_o), .lk_hit_o(lk_hit_o), .lk_pfn_o(lk_pfn_o),
    .lk_glb_o(lk_glb_o), .root_o(root_o)
  );

  typedef struct {
    logic        hit;
    logic [19:0] pfn;
    logic        glb;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  task automatic step();
    @(posedge clk); #1;
    fill_i = 0; root_wr_i = 0; flush_all_i = 0; lk_req_i = 0;
  endtask

  task automatic put_fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic glb);
    fill_i = 1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_glb_i = glb;
  endtask

  task automatic put_root(input logic [31:0] val, input logic keep);
    root_wr_i = 1; root_val_i = val; root_keep_i = keep;
  endtask

  task automatic put_lk(input logic [19:0] vpn, input logic hit,
                        input logic [19:0] pfn, input logic glb, input string req);
    exp_t e;
    lk_req_i = 1; lk_vpn_i = vpn;
    e.hit = hit; e.pfn = hit ? pfn : 20'h0; e.glb = hit ? glb : 1'b0; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic hit,
                        input logic [19:0] pfn, input logic glb, input string req);
    put_lk(vpn, hit, pfn, glb, req);
    step();
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic glb);
    put_fill(vpn, pfn, glb);
    step();
  endtask

  task automatic root(input logic [31:0] val, input logic keep);
    put_root(val, keep);
    step();
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per valid response
  always @(negedge clk) begin
    if (rst_n && lk_vld_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected response expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (lk_hit_o !== e.hit || lk_pfn_o !== e.pfn || lk_glb_o !== e.glb) begin
          n_bad++;
          $display("FAIL %s: actual hit=%0b pfn=%0h glb=%0b expected hit=%0b pfn=%0h glb=%0b",
                   e.req, lk_hit_o, lk_pfn_o, lk_glb_o, e.hit, e.pfn, e.glb);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tag_en_i = 0; root_wr_i = 0; root_val_i = 0; root_keep_i = 0;
    flush_all_i = 0; fill_i = 0; fill_vpn_i = 0; fill_pfn_i = 0; fill_glb_i = 0;
    lk_req_i = 0; lk_vpn_i = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(32'(lk_vld_o), 32'd0, "R1");
    check(root_o, 32'd0, "R1");
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    lookup(20'h5, 0, 0, 0, "R1");

    // Untagged operation
    fill(20'h5, 20'hA5, 0);
    fill(20'h6, 20'hB6, 1);
    lookup(20'h5, 1, 20'hA5, 0, "R2");
    lookup(20'h6, 1, 20'hB6, 1, "R3");
    lookup(20'h9, 0, 0, 0, "R3");

    // R8: same-cycle lookup sees old contents
    put_root(32'h1234_0ABC, 0);
    put_lk(20'h5, 1, 20'hA5, 0, "R8");
    step();
    check(root_o, 32'h1234_0ABC, "R12");
    lookup(20'h5, 0, 0, 0, "R4");
    lookup(20'h6, 1, 20'hB6, 1, "R4");

    // Tagged operation
    tag_en_i = 1;
    root(32'h0000_5001, 0);
    fill(20'h7, 20'hC7, 0);
    root(32'h0000_5002, 1);
    lookup(20'h7, 0, 0, 0, "R3");
    lookup(20'h6, 1, 20'hB6, 1, "R7");
    fill(20'h8, 20'hD8, 0);
    root(32'h0000_5001, 1);
    lookup(20'h7, 1, 20'hC7, 0, "R5");
    lookup(20'h8, 0, 0, 0, "R3");
    root(32'h0000_5002, 0);
    root(32'h0000_5001, 1);
    lookup(20'h7, 1, 20'hC7, 0, "R6");
    root(32'h0000_5002, 1);
    lookup(20'h8, 0, 0, 0, "R6");
    lookup(20'h6, 1, 20'hB6, 1, "R7");
    check(root_o, 32'h0000_5002, "R12");

    // Tagging off without a write: effective tag forced to zero
    root(32'h0000_5001, 1);
    tag_en_i = 0;
    lookup(20'h7, 0, 0, 0, "R3");
    lookup(20'h6, 1, 20'hB6, 1, "R7");

    // R11: wipe removes global entries
    flush_all_i = 1; step();
    lookup(20'h6, 0, 0, 0, "R11");

    // R9: refill in place
    fill(20'h40, 20'h1, 0);
    fill(20'h40, 20'h2, 0);
    lookup(20'h40, 1, 20'h2, 0, "R9");
    for (int k = 1; k < 16; k++) fill(20'h40 + 20'(k), 20'h300 + 20'(k), 0);
    lookup(20'h40, 1, 20'h2, 0, "R9");
    lookup(20'h41, 1, 20'h301, 0, "R9");

    // R10: round-robin from entry 0
    fill(20'h50, 20'h350, 0);
    lookup(20'h40, 0, 0, 0, "R10");
    lookup(20'h41, 1, 20'h301, 0, "R10");
    lookup(20'h50, 1, 20'h350, 0, "R10");
    fill(20'h51, 20'h351, 0);
    lookup(20'h41, 0, 0, 0, "R10");
    lookup(20'h42, 1, 20'h302, 0, "R10");

    // R11: fill in wipe cycle is dropped
    put_fill(20'h60, 20'h360, 1);
    flush_all_i = 1;
    step();
    lookup(20'h60, 0, 0, 0, "R11");
    lookup(20'h42, 0, 0, 0, "R11");

    repeat (4) step();
    check(32'(exp_q.size()), 32'd0, "R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule